// File: doc/BRIEF.md
# Cartridge RAM Paging Controller

This block is the glue logic of an expansion cartridge that carries 8 KB of static RAM and no ROM. It observes a Z80-style host bus (address, IORQ, MREQ, RD, WR, M1, all active low). It takes its paging control from the address lines of writes to a decoded, write-only I/O port. The data bus plays no part in paging. Two flags come out of the port. One removes the host ROM from the map and lets the lower SRAM half (0x0000–0x0FFF) be read in its place. The other removes the host RAM and lets the upper SRAM half (0x1000–0x1FFF) be read and written. Address bit 13 is not decoded, so the window also appears at 0x2000–0x3FFF.

The block produces chip-select, output-enable and write-enable for the local SRAM, and it drives the SRAM's address bit 12. A load/save switch, synchronised to the clock, swaps the two halves by inverting that address bit. A front-panel button, synchronised and debounced, raises a non-maskable interrupt request. The request holds until the host fetches the opcode at 0x0066.

Top module: `cart_page_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, rom_off and ram_off become 0, nmi_n becomes 1, and, with the bus idle, sram_cs_n, sram_oe_n and sram_we_n are 1.
- R2: A port write is a clock edge at which iorq_n=0, wr_n=0, addr[10]=0 and addr[2]=0. Only a port write updates the flags, and the new values are visible after that edge. I/O writes with addr[10]=1 or addr[2]=1, I/O reads, and memory writes leave both flags unchanged.
- R3: A port write sets rom_off to the value of addr[8].
- R4: A port write sets ram_off to the value of addr[9].
- R5: While rom_off=1, a memory read (mreq_n=0, rd_n=0) at 0x0000–0x0FFF drives sram_cs_n and sram_oe_n low in the same cycle. A memory write there never drives sram_we_n low.
- R6: While ram_off=1, a memory read at 0x1000–0x1FFF drives sram_cs_n and sram_oe_n low, and a memory write there drives sram_cs_n and sram_we_n low, in the same cycle.
- R7: No SRAM strobe is driven for an access to a half whose flag is 0, nor for any address with addr[15:14] not equal to 00.
- R8: Addresses 0x2000–0x3FFF behave exactly as 0x0000–0x1FFF, because addr[13] is ignored.
- R9: sram_a12 equals addr[12] XOR the synchronised load_sw. A change of load_sw shows on sram_a12 after the second clock edge that follows it.
- R10: btn_n sampled low for DEB_CYCLES consecutive synchroniser outputs drives nmi_n low. A shorter press has no effect, and a press that is still held causes only one request.
- R11: nmi_n stays low until a clock edge with m1_n=0, mreq_n=0, rd_n=0 and addr=0x0066, and it is 1 after that edge. Fetches at other addresses do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Host address bus |
| iorq_n | input | 1 | Host I/O request, active low |
| mreq_n | input | 1 | Host memory request, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| m1_n | input | 1 | Host opcode-fetch cycle, active low |
| load_sw | input | 1 | Load/save switch, asynchronous |
| btn_n | input | 1 | NMI button, active low, asynchronous, bouncing |
| rom_off | output | 1 | Removes the host ROM from the map |
| ram_off | output | 1 | Removes the host RAM from the map |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_a12 | output | 1 | SRAM address bit 12 |

## Verification
The SRAM strobes depend combinationally on the bus and the flags, so the bench applies each memory cycle after a falling clock edge and samples 2 ns later, with no clock edge in between. A flag change is due after the single rising edge that falls inside a port-write cycle, so the bench reads the flags at the following falling edge. The switch is checked at the falling edge after the first rising edge (still old value) and after the second (new value). The button is checked one edge before and at the edge where the request is due: DEB_CYCLES+2 rising edges after btn_n falls, with the first of those edges counted as one.

// File: rtl/cart_pkg.sv
// Package: shared constants and types of the cartridge paging controller.
// Assumes a 16-bit Z80-style host address bus.
package cart_pkg;
    localparam int          HOST_AW      = 16;
    localparam int          SEL_ZERO_HI  = 10;  // must be 0 to select port
    localparam int          SEL_ZERO_LO  = 2;   // must be 0 to select port
    localparam int          ROM_OFF_BIT  = 8;   // address bit carrying ROM flag
    localparam int          RAM_OFF_BIT  = 9;   // address bit carrying RAM flag
    localparam logic [15:0] NMI_ACK_ADDR = 16'h0066;

    typedef struct packed {
        logic rom_off;
        logic ram_off;
    } page_flags_t;
endpackage

// File: rtl/cart_sync2.sv
// Module: two-flop synchroniser for a single asynchronous input.
// Assumes the input is a slow level (switch or button); RST_VAL is the
// level taken during synchronous active-low reset.
module cart_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;

    // Purpose: shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/cart_port_latch.sv
// Module: decodes the write-only control port and holds the paging flags.
// Assumes bus strobes are sampled at the clock edge. The flag values come
// from address lines of the I/O write; the data bus is not used.
module cart_port_latch
    import cart_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iorq_n,
    input  logic        wr_n,
    input  logic        a_sel_hi,
    input  logic        a_sel_lo,
    input  logic        a_rom,
    input  logic        a_ram,
    output page_flags_t flags
);
    logic port_wr;

    // Purpose: recognise an I/O write cycle that addresses the control port.
    always_comb port_wr = !iorq_n && !wr_n && !a_sel_hi && !a_sel_lo;

    // Purpose: load both flags from the address lines on a port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (port_wr) begin
            flags.rom_off <= a_rom;
            flags.ram_off <= a_ram;
        end
    end

    a_r3_rom_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (flags.rom_off == $past(a_rom)));
    a_r4_ram_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (flags.ram_off == $past(a_ram)));
    a_r2_hold_without_port: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(flags));
endmodule

// File: rtl/cart_sram_decode.sv
// Module: combinational SRAM strobe decode from the host memory cycle.
// Assumes addr_hi carries host addr[15:12]; addr[13] is deliberately ignored.
// The lower half is a read-only overlay, the upper half is read/write.
module cart_sram_decode
    import cart_pkg::*;
(
    input  logic        mreq_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [3:0]  addr_hi,
    input  logic        swap,
    input  page_flags_t flags,
    output logic        sram_cs_n,
    output logic        sram_oe_n,
    output logic        sram_we_n,
    output logic        sram_a12
);
    logic in_window, upper, lower_hit, upper_hit, rd_hit, wr_hit;
    logic unused_a13;

    // Purpose: locate the access within the mirrored 8 KB window.
    always_comb begin
        unused_a13 = addr_hi[1];
        in_window  = (addr_hi[3:2] == 2'b00);
        upper      = addr_hi[0];
        lower_hit  = in_window && !upper && flags.rom_off;
        upper_hit  = in_window &&  upper && flags.ram_off;
    end

    // Purpose: qualify the window hit with the memory cycle type.
    always_comb begin
        rd_hit    = !mreq_n && !rd_n && (lower_hit || upper_hit);
        wr_hit    = !mreq_n && !wr_n && upper_hit;
        sram_oe_n = !rd_hit;
        sram_we_n = !wr_hit;
        sram_cs_n = !(rd_hit || wr_hit);
        sram_a12  = addr_hi[0] ^ swap;
    end
endmodule

// File: rtl/cart_nmi_gen.sv
// Module: debounced button to one-shot NMI request with fetch acknowledge.
// Assumes btn_n is already synchronised. DEB_CYCLES must be at least 2.
// The acknowledge (M1 read at the vector) wins over a new press.
module cart_nmi_gen
    import cart_pkg::*;
#(
    parameter int DEB_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_sync_n,
    input  logic               m1_n,
    input  logic               mreq_n,
    input  logic               rd_n,
    input  logic [HOST_AW-1:0] addr,
    output logic               nmi_n
);
    localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          level_n;
    logic          pending;
    logic          press, ack;

    // Purpose: detect the cycle the debounced level goes to pressed,
    // and the vector fetch that acknowledges the request.
    always_comb begin
        press = (btn_sync_n != level_n) && (cnt == CNT_LAST) && !btn_sync_n;
        ack   = !m1_n && !mreq_n && !rd_n && (addr == NMI_ACK_ADDR);
    end

    // Purpose: accept a new level only after it holds for DEB_CYCLES samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            level_n <= 1'b1;
        end else if (btn_sync_n == level_n) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt     <= '0;
            level_n <= btn_sync_n;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: hold the request from a press until the vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (ack)   pending <= 1'b0;
        else if (press) pending <= 1'b1;
    end

    always_comb nmi_n = !pending;

    a_r10_level_needs_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_n) |-> ($past(cnt) == CNT_LAST));
    a_r11_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ack) |=> !pending);
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
endmodule

// File: rtl/cart_page_ctrl.sv
// Module: top of the cartridge RAM paging controller.
// Assumes a Z80-style bus with active-low strobes, sampled on clk; the
// SRAM strobes follow the bus combinationally. Reset is synchronous, active low.
module cart_page_ctrl
    import cart_pkg::*;
#(
    parameter int DEB_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        iorq_n,
    input  logic        mreq_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        m1_n,
    input  logic        load_sw,
    input  logic        btn_n,
    output logic        rom_off,
    output logic        ram_off,
    output logic        nmi_n,
    output logic        sram_cs_n,
    output logic        sram_oe_n,
    output logic        sram_we_n,
    output logic        sram_a12
);
    page_flags_t flags;
    logic        swap_sync;
    logic        btn_sync_n;

    cart_sync2 #(.RST_VAL(1'b0)) u_sw_sync (
        .clk(clk), .rst_n(rst_n), .d_async(load_sw), .q_sync(swap_sync));

    cart_sync2 #(.RST_VAL(1'b1)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .d_async(btn_n), .q_sync(btn_sync_n));

    cart_port_latch u_latch (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr_n(wr_n),
        .a_sel_hi(addr[SEL_ZERO_HI]), .a_sel_lo(addr[SEL_ZERO_LO]),
        .a_rom(addr[ROM_OFF_BIT]), .a_ram(addr[RAM_OFF_BIT]),
        .flags(flags));

    cart_sram_decode u_decode (
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr[15:12]),
        .swap(swap_sync), .flags(flags),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_a12(sram_a12));

    cart_nmi_gen #(.DEB_CYCLES(DEB_CYCLES)) u_nmi (
        .clk(clk), .rst_n(rst_n), .btn_sync_n(btn_sync_n), .m1_n(m1_n),
        .mreq_n(mreq_n), .rd_n(rd_n), .addr(addr), .nmi_n(nmi_n));

    // Purpose: bring the held flags out to the host lines.
    always_comb begin
        rom_off = flags.rom_off;
        ram_off = flags.ram_off;
    end

    a_r5_no_write_to_overlay: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (addr[12] && ram_off));
    a_r7_outside_window_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] != 2'b00) |-> sram_cs_n);
endmodule

// File: tb/tb_cart_page_ctrl.sv
module tb_cart_page_ctrl;
    localparam int DEB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic        load_sw = 1'b0, btn_n = 1'b1;
    logic        rom_off, ram_off, nmi_n, sram_cs_n, sram_oe_n, sram_we_n, sram_a12;

    int checks = 0;
    int failures = 0;

    cart_page_ctrl #(.DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n),
        .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .load_sw(load_sw), .btn_n(btn_n),
        .rom_off(rom_off), .ram_off(ram_off), .nmi_n(nmi_n), .sram_cs_n(sram_cs_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_a12(sram_a12));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    endtask

    // One port-sized I/O cycle spanning a single rising edge.
    task automatic io_cycle(input logic [15:0] a, input logic is_wr);
        @(negedge clk);
        addr = a; iorq_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        bus_idle();
        #1;
    endtask

    // Apply a memory cycle between edges and return the strobes {cs,oe,we}.
    task automatic mem_probe(input logic [15:0] a, input logic is_wr, output logic [2:0] s);
        @(negedge clk);
        addr = a; mreq_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        #2;
        s = {sram_cs_n, sram_oe_n, sram_we_n};
        bus_idle();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 rom_off", {7'd0, rom_off}, 8'd0);
        check("R1 ram_off", {7'd0, ram_off}, 8'd0);
        check("R1 nmi_n",   {7'd0, nmi_n},   8'd1);
        check("R1 strobes", {5'd0, sram_cs_n, sram_oe_n, sram_we_n}, 8'h07);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_port_decode();
        io_cycle(16'h0700, 1'b1);   // addr[10]=1: not the port
        check("R2 a10 high ignored", {6'd0, rom_off, ram_off}, 8'h00);
        io_cycle(16'h0304, 1'b1);   // addr[2]=1: not the port
        check("R2 a2 high ignored", {6'd0, rom_off, ram_off}, 8'h00);
        io_cycle(16'h0300, 1'b0);   // I/O read
        check("R2 io read ignored", {6'd0, rom_off, ram_off}, 8'h00);
        begin
            logic [2:0] s;
            mem_probe(16'h0300, 1'b1, s);
            @(negedge clk); #1;
            check("R2 mem write ignored", {6'd0, rom_off, ram_off}, 8'h00);
        end
        io_cycle(16'h0100, 1'b1);
        check("R3 rom set", {6'd0, rom_off, ram_off}, 8'h02);
        io_cycle(16'h0200, 1'b1);
        check("R4 ram set rom clear", {6'd0, rom_off, ram_off}, 8'h01);
        io_cycle(16'h83F8, 1'b1);   // other bits free, a10=a2=0, a8=a9=1
        check("R3 R4 both set", {6'd0, rom_off, ram_off}, 8'h03);
        io_cycle(16'h0000, 1'b1);
        check("R3 R4 both clear", {6'd0, rom_off, ram_off}, 8'h00);
    endtask

    task automatic t_windows();
        logic [2:0] s;
        mem_probe(16'h0123, 1'b0, s);
        check("R7 overlay read flag off", {5'd0, s}, 8'h07);
        mem_probe(16'h1123, 1'b1, s);
        check("R7 upper write flag off", {5'd0, s}, 8'h07);
        io_cycle(16'h0100, 1'b1);
        mem_probe(16'h0ABC, 1'b0, s);
        check("R5 overlay read", {5'd0, s}, 8'h01);
        mem_probe(16'h0ABC, 1'b1, s);
        check("R5 overlay write ignored", {5'd0, s}, 8'h07);
        mem_probe(16'h1ABC, 1'b0, s);
        check("R7 upper read with ram_off=0", {5'd0, s}, 8'h07);
        io_cycle(16'h0300, 1'b1);
        mem_probe(16'h1ABC, 1'b0, s);
        check("R6 upper read", {5'd0, s}, 8'h01);
        mem_probe(16'h1FFF, 1'b1, s);
        check("R6 upper write", {5'd0, s}, 8'h02);
        mem_probe(16'h2010, 1'b0, s);
        check("R8 mirror lower read", {5'd0, s}, 8'h01);
        mem_probe(16'h3010, 1'b1, s);
        check("R8 mirror upper write", {5'd0, s}, 8'h02);
        mem_probe(16'h2010, 1'b1, s);
        check("R8 mirror overlay write ignored", {5'd0, s}, 8'h07);
        mem_probe(16'h4010, 1'b0, s);
        check("R7 above window read", {5'd0, s}, 8'h07);
        mem_probe(16'hD000, 1'b1, s);
        check("R7 above window write", {5'd0, s}, 8'h07);
        io_cycle(16'h0200, 1'b1);
        mem_probe(16'h0ABC, 1'b0, s);
        check("R7 overlay off after clear", {5'd0, s}, 8'h07);
    endtask

    task automatic t_switch();
        @(negedge clk);
        addr = 16'h0000;
        #1;
        check("R9 a12 plain", {7'd0, sram_a12}, 8'd0);
        load_sw = 1'b1;
        @(negedge clk); #1;
        check("R9 a12 after one edge", {7'd0, sram_a12}, 8'd0);
        @(negedge clk); #1;
        check("R9 a12 swapped", {7'd0, sram_a12}, 8'd1);
        addr = 16'h1000; #1;
        check("R9 upper swapped", {7'd0, sram_a12}, 8'd0);
        load_sw = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R9 upper restored", {7'd0, sram_a12}, 8'd1);
    endtask

    task automatic t_nmi();
        // Short press: DEB/2 cycles low.
        @(negedge clk);
        btn_n = 1'b0;
        repeat (DEB / 2) @(negedge clk);
        btn_n = 1'b1;
        repeat (DEB + 4) @(posedge clk);
        #1;
        check("R10 short press ignored", {7'd0, nmi_n}, 8'd1);
        // Full press, timed to the edge.
        @(negedge clk);
        btn_n = 1'b0;
        repeat (DEB + 1) @(posedge clk);
        #1;
        check("R10 not yet", {7'd0, nmi_n}, 8'd1);
        @(posedge clk); #1;
        check("R10 request raised", {7'd0, nmi_n}, 8'd0);
        // Fetch at another address does not release.
        @(negedge clk);
        addr = 16'h0067; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        bus_idle(); #1;
        check("R11 other fetch keeps", {7'd0, nmi_n}, 8'd0);
        // Plain read of the vector (no M1) does not release.
        @(negedge clk);
        addr = 16'h0066; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        bus_idle(); #1;
        check("R11 non-M1 read keeps", {7'd0, nmi_n}, 8'd0);
        @(negedge clk);
        addr = 16'h0066; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        #2;
        check("R11 held before edge", {7'd0, nmi_n}, 8'd0);
        @(negedge clk);
        bus_idle(); #1;
        check("R11 vector fetch releases", {7'd0, nmi_n}, 8'd1);
        repeat (DEB + 4) @(posedge clk);
        #1;
        check("R10 held button no repeat", {7'd0, nmi_n}, 8'd1);
        @(negedge clk);
        btn_n = 1'b1;
        repeat (DEB + 4) @(negedge clk);
        btn_n = 1'b0;
        repeat (DEB + 4) @(posedge clk);
        #1;
        check("R10 second press", {7'd0, nmi_n}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_port_decode();
        t_windows();
        t_switch();
        t_nmi();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule